// File: doc/BRIEF.md
# Burst-Paced DMA Transfer Engine

A single-channel data mover that copies a programmed number of bytes from a read port to a write port. A start pulse captures the job: both addresses, the byte count minus one, the access width and the address-increment enable for each side, the burst length minus one, and whether bursts wait for a peripheral request. The engine then moves the data in bursts. Each burst drains through a small byte buffer, so a narrow read side can feed a wide write side, and a wide read side can feed a narrow write side, without losing or duplicating bytes.

A fixed (non-incrementing) address stands for a peripheral data register. An incrementing address stands for memory. Memory-to-peripheral, peripheral-to-memory and memory-to-memory moves are all set up through the two increment enables. A live remaining-count output shows how many bytes are still to be written, in minus-one form. A cancel input stops the job at once. Both memory ports use a simple request/grant handshake. The read data is valid in the cycle of the grant.

Top module: `dma_xfer_engine`

## Requirements
- R1: A start pulse while idle captures every configuration input and sets `busy_o`. On the next cycle `remaining_o` equals `size_m1_i`. A start pulse while busy has no effect, and neither does a change to the configuration inputs after the start.
- R2: `remaining_o` drops by the byte count of every granted write. When it wraps to all ones (no bytes left), `done_o` pulses for exactly one cycle in the same cycle that `busy_o` falls.
- R3: The written byte stream equals the read byte stream in order. Within an access, byte k sits at data bits [8k+7:8k], and the lowest byte comes first.
- R4: A width code w (0..3) means 2^w bytes. Each read moves min(2^w_rd, bytes left to read in the burst). Each write moves min(2^w_wr, bytes left to write in the burst). The length of each access is shown on `rd_len_o` / `wr_len_o`.
- R5: With its increment enable set, an address advances by the length of each granted access on its side. Without it, the address stays at its start value.
- R6: Each burst carries min(`burst_m1_i`+1, bytes remaining) bytes and is fully written before the next burst starts. When `req_en_i` is set, no burst starts until `periph_req_i` is high.
- R7: A cancel while busy withholds all requests in that cycle. It clears `busy_o` on the next edge without a `done_o` pulse and freezes `remaining_o`. No further accesses follow. A later transfer starts with an empty buffer.
- R8: After reset, `busy_o` and `done_o` are low, `remaining_o` is all ones, and no request is raised.
- R9: While `busy_o` is low, `rd_req_o` and `wr_req_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration |
| cancel_i | input | 1 | Abort of the active transfer |
| src_addr_i | input | 32 | Start read address |
| dst_addr_i | input | 32 | Start write address |
| size_m1_i | input | 24 | Byte count minus one |
| rd_width_i | input | 3 | Read access width, log2 bytes |
| wr_width_i | input | 3 | Write access width, log2 bytes |
| rd_inc_i | input | 1 | Read address increment enable |
| wr_inc_i | input | 1 | Write address increment enable |
| burst_m1_i | input | 8 | Burst size in bytes minus one |
| req_en_i | input | 1 | Bursts wait for the peripheral request |
| periph_req_i | input | 1 | Peripheral request |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_len_o | output | 4 | Read byte count |
| rd_gnt_i | input | 1 | Read grant; data valid in this cycle |
| rd_data_i | input | 64 | Read data, little-endian bytes |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write address |
| wr_len_o | output | 4 | Write byte count |
| wr_data_o | output | 64 | Write data, little-endian bytes |
| wr_gnt_i | input | 1 | Write grant |
| busy_o | output | 1 | Transfer active |
| done_o | output | 1 | One-cycle completion pulse |
| remaining_o | output | 24 | Bytes left to write, minus one |

## Verification
The properties assume that `size_m1_i` is stable in the cycle of a start pulse, that width codes stay within 0..3, and that grants arrive only as the answer to a raised request in the same cycle. The stimulus applies every configuration change, start and cancel one time unit after a clock edge. It sweeps all read/write width pairs over the three increment modes with a multi-burst length. Grants follow a pseudo-random pattern, so that the buffer runs both full and empty. Separate cases cover single-byte jobs, bursts longer than the job, one-byte bursts, request pacing and cancel.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_MOVE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/dma_chunk_len.sv
module dma_chunk_len #(
  parameter int unsigned BUS_BYTES = 8,
  parameter int unsigned LEFT_W    = 9,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [2:0]        width_i,
  input  logic [LEFT_W-1:0] left_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned MAX_LOG = $clog2(BUS_BYTES);

  logic [LEFT_W-1:0] cap;

  always_comb begin
    if (width_i > 3'(MAX_LOG)) cap = LEFT_W'(BUS_BYTES);
    else                       cap = LEFT_W'(1) << width_i;
    len_o = (left_i < cap) ? LEN_W'(left_i) : LEN_W'(cap);
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    base_i,
  input  logic             inc_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [AW-1:0]    addr_o
);
  logic inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      inc_q  <= 1'b0;
    end else if (load_i) begin
      addr_o <= base_i;
      inc_q  <= inc_i;
    end else if (step_i && inc_q) begin
      addr_o <= addr_o + AW'(len_i);
    end
  end
endmodule

// File: rtl/dma_byte_buf.sv
module dma_byte_buf #(
  parameter int unsigned BUS_BYTES = 8,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned LVL_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   push_i,
  input  logic [LEN_W-1:0]       push_len_i,
  input  logic [BUS_BYTES*8-1:0] push_data_i,
  input  logic                   pop_i,
  input  logic [LEN_W-1:0]       pop_len_i,
  output logic [LVL_W-1:0]       level_o,
  output logic [BUS_BYTES*8-1:0] head_o
);
  localparam int unsigned IDX_W = $clog2(BUF_BYTES);
  localparam int unsigned BI_W  = $clog2(BUS_BYTES);

  logic [7:0]       mem_q [BUF_BYTES];
  logic [7:0]       mem_d [BUF_BYTES];
  logic [7:0]       in_b  [BUS_BYTES];
  logic [LVL_W-1:0] lvl_q, lvl_d;

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    assign in_b[g]          = push_data_i[g*8 +: 8];
    assign head_o[g*8 +: 8] = mem_q[g];
  end

  // Shift out popped bytes, append pushed bytes behind the survivors
  always_comb begin
    int popn;
    int pushn;
    int keep;
    popn  = pop_i  ? int'(pop_len_i)  : 0;
    pushn = push_i ? int'(push_len_i) : 0;
    keep  = int'(lvl_q) - popn;
    for (int i = 0; i < int'(BUF_BYTES); i++) begin
      mem_d[i] = 8'h00;
      if (i < keep) begin
        if (i + popn < int'(BUF_BYTES)) mem_d[i] = mem_q[IDX_W'(i + popn)];
      end else if (i < keep + pushn) begin
        mem_d[i] = in_b[BI_W'(i - keep)];
      end
    end
    lvl_d = LVL_W'(keep + pushn);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      for (int i = 0; i < int'(BUF_BYTES); i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      for (int i = 0; i < int'(BUF_BYTES); i++) mem_q[i] <= mem_d[i];
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned BURST_W   = 8,
  parameter int unsigned BUS_BYTES = 8,
  parameter int unsigned BUF_BYTES = 16,
  localparam int unsigned DW       = BUS_BYTES * 8,
  localparam int unsigned LEN_W    = $clog2(BUS_BYTES) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cancel_i,
  input  logic [AW-1:0]      src_addr_i,
  input  logic [AW-1:0]      dst_addr_i,
  input  logic [CNT_W-1:0]   size_m1_i,
  input  logic [2:0]         rd_width_i,
  input  logic [2:0]         wr_width_i,
  input  logic               rd_inc_i,
  input  logic               wr_inc_i,
  input  logic [BURST_W-1:0] burst_m1_i,
  input  logic               req_en_i,
  input  logic               periph_req_i,
  output logic               rd_req_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic [LEN_W-1:0]   rd_len_o,
  input  logic               rd_gnt_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               wr_req_o,
  output logic [AW-1:0]      wr_addr_o,
  output logic [LEN_W-1:0]   wr_len_o,
  output logic [DW-1:0]      wr_data_o,
  input  logic               wr_gnt_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   remaining_o
);
  localparam int unsigned LVL_W = $clog2(BUF_BYTES) + 1;
  localparam int unsigned BL_W  = BURST_W + 1;
  localparam int unsigned RP_W  = CNT_W + 1;

  xfer_state_e        state_q;
  logic [CNT_W-1:0]   rem_q, rem_nx;
  logic [BL_W-1:0]    brd_q, bwr_q, bwr_nx, bl, bur_p1;
  logic [RP_W-1:0]    rem_p1;
  logic [2:0]         rw_q, ww_q;
  logic [BURST_W-1:0] burst_q;
  logic               req_en_q, done_q;
  logic [LVL_W-1:0]   level;
  logic [LEN_W-1:0]   rd_n, wr_n;
  logic               start_ok, abort, room, rd_hs, wr_hs, moving;

  assign start_ok = start_i && (state_q == XS_IDLE);
  assign abort    = cancel_i && (state_q != XS_IDLE);
  assign moving   = (state_q == XS_MOVE) && !cancel_i;

  // Burst size: the smaller of the programmed burst and the bytes left
  assign rem_p1 = {1'b0, rem_q} + RP_W'(1);
  assign bur_p1 = {1'b0, burst_q} + BL_W'(1);
  assign bl     = (rem_p1 < RP_W'(bur_p1)) ? BL_W'(rem_p1) : bur_p1;

  dma_chunk_len #(.BUS_BYTES(BUS_BYTES), .LEFT_W(BL_W), .LEN_W(LEN_W)) i_rd_chunk (
    .width_i(rw_q), .left_i(brd_q), .len_o(rd_n)
  );
  dma_chunk_len #(.BUS_BYTES(BUS_BYTES), .LEFT_W(BL_W), .LEN_W(LEN_W)) i_wr_chunk (
    .width_i(ww_q), .left_i(bwr_q), .len_o(wr_n)
  );

  assign room     = ({1'b0, level} + (LVL_W+1)'(rd_n)) <= (LVL_W+1)'(BUF_BYTES);
  assign rd_req_o = moving && (brd_q != '0) && room;
  assign wr_req_o = moving && (bwr_q != '0) && (level >= LVL_W'(wr_n));
  assign rd_hs    = rd_req_o && rd_gnt_i;
  assign wr_hs    = wr_req_o && wr_gnt_i;
  assign rd_len_o = rd_n;
  assign wr_len_o = wr_n;
  assign rem_nx   = rem_q - CNT_W'(wr_n);
  assign bwr_nx   = bwr_q - BL_W'(wr_n);

  dma_addr_ctr #(.AW(AW), .LEN_W(LEN_W)) i_rd_addr (
    .clk_i, .rst_ni, .load_i(start_ok), .base_i(src_addr_i), .inc_i(rd_inc_i),
    .step_i(rd_hs), .len_i(rd_n), .addr_o(rd_addr_o)
  );
  dma_addr_ctr #(.AW(AW), .LEN_W(LEN_W)) i_wr_addr (
    .clk_i, .rst_ni, .load_i(start_ok), .base_i(dst_addr_i), .inc_i(wr_inc_i),
    .step_i(wr_hs), .len_i(wr_n), .addr_o(wr_addr_o)
  );

  dma_byte_buf #(
    .BUS_BYTES(BUS_BYTES), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .LVL_W(LVL_W)
  ) i_buf (
    .clk_i, .rst_ni, .flush_i(start_ok || abort),
    .push_i(rd_hs), .push_len_i(rd_n), .push_data_i(rd_data_i),
    .pop_i(wr_hs), .pop_len_i(wr_n), .level_o(level), .head_o(wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= XS_IDLE;
      rem_q    <= '1;
      brd_q    <= '0;
      bwr_q    <= '0;
      rw_q     <= '0;
      ww_q     <= '0;
      burst_q  <= '0;
      req_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        state_q  <= XS_WAIT;
        rem_q    <= size_m1_i;
        rw_q     <= rd_width_i;
        ww_q     <= wr_width_i;
        burst_q  <= burst_m1_i;
        req_en_q <= req_en_i;
        brd_q    <= '0;
        bwr_q    <= '0;
      end else if (abort) begin
        state_q <= XS_IDLE;
        brd_q   <= '0;
        bwr_q   <= '0;
      end else begin
        case (state_q)
          XS_WAIT: begin
            if (!req_en_q || periph_req_i) begin
              brd_q   <= bl;
              bwr_q   <= bl;
              state_q <= XS_MOVE;
            end
          end
          XS_MOVE: begin
            if (rd_hs) brd_q <= brd_q - BL_W'(rd_n);
            if (wr_hs) begin
              rem_q <= rem_nx;
              bwr_q <= bwr_nx;
              if (rem_nx == '1) begin
                state_q <= XS_IDLE;
                done_q  <= 1'b1;
              end else if (bwr_nx == '0) begin
                state_q <= XS_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o      = (state_q != XS_IDLE);
  assign done_o      = done_q;
  assign remaining_o = rem_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned BUS_BYTES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cancel_i,
  input logic [CNT_W-1:0] size_m1_i,
  input logic             rd_req_o,
  input logic [LEN_W-1:0] rd_len_o,
  input logic             wr_req_o,
  input logic [LEN_W-1:0] wr_len_o,
  input logic             wr_gnt_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] remaining_o
);
  // R1
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && remaining_o == $past(size_m1_i)));

  // R2
  rem_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_gnt_i) |=> (remaining_o == $past(remaining_o) - CNT_W'($past(wr_len_o))));

  // R2
  rem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(wr_req_o && wr_gnt_i)) |=> $stable(remaining_o));

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && remaining_o == '1));

  // R4
  rd_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_len_o != '0 && rd_len_o <= LEN_W'(BUS_BYTES)));

  // R4
  wr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_len_o != '0 && wr_len_o <= LEN_W'(BUS_BYTES)));

  // R7
  cancel_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cancel_i) |=> (!busy_o && !done_o));

  // R7
  cancel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |-> (!rd_req_o && !wr_req_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !wr_req_o));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)
) i_dma_xfer_engine_chk (.*);

// File: tb/test_dma_xfer_engine.sv
`timescale 1ns/1ps
module test_dma_xfer_engine;
  localparam int AW = 32, CNT_W = 24, DW = 64, LEN_W = 4;

  logic clk, rst_n, start, cancel, rinc, winc, req_en, preq;
  logic [AW-1:0] src, dst, rd_addr, wr_addr;
  logic [CNT_W-1:0] size_m1, remaining;
  logic [2:0] rwid, wwid;
  logic [7:0] bm1;
  logic rd_req, rd_gnt, wr_req, wr_gnt, busy, done;
  logic [LEN_W-1:0] rd_len, wr_len;
  logic [DW-1:0] rd_data, wr_data;
  logic [15:0] lfsr;

  int checks = 0, errors = 0;
  int rd_cnt, wr_cnt, done_cnt, wb;
  logic [31:0] rd_a [256];
  int rd_l [256];
  logic [31:0] wr_a [256];
  int wr_l [256];
  logic [7:0] stream [1024];
  logic [7:0] exp_s [1024];

  dma_xfer_engine i_dma_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cancel_i(cancel),
    .src_addr_i(src), .dst_addr_i(dst), .size_m1_i(size_m1),
    .rd_width_i(rwid), .wr_width_i(wwid), .rd_inc_i(rinc), .wr_inc_i(winc),
    .burst_m1_i(bm1), .req_en_i(req_en), .periph_req_i(preq),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_gnt_i(rd_gnt),
    .rd_data_i(rd_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_len_o(wr_len),
    .wr_data_o(wr_data), .wr_gnt_i(wr_gnt), .busy_o(busy), .done_o(done),
    .remaining_o(remaining)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb
    for (int k = 0; k < 8; k++) rd_data[k*8 +: 8] = pat(rd_addr + 32'(k));

  initial lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign rd_gnt = lfsr[0] | lfsr[3];
  assign wr_gnt = lfsr[5] | lfsr[9];

  // Handshake log, sampled mid-cycle
  always @(negedge clk) begin
    if (rd_req && rd_gnt) begin
      if (rd_cnt < 256) begin rd_a[rd_cnt] = rd_addr; rd_l[rd_cnt] = int'(rd_len); end
      rd_cnt++;
    end
    if (wr_req && wr_gnt) begin
      if (wr_cnt < 256) begin wr_a[wr_cnt] = wr_addr; wr_l[wr_cnt] = int'(wr_len); end
      for (int k = 0; k < int'(wr_len); k++) begin
        if (wb < 1024) stream[wb] = wr_data[k*8 +: 8];
        wb++;
      end
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; wb = 0;
  endtask

  task automatic run(input int len, input int rw, input int ww, input bit ri,
                     input bit wi, input int b, input bit rq, input bit hold);
    logic [31:0] s, d;
    int pos, ri_n, wi_n, bad_len, bad_addr, bad_dat, t;
    s = 32'h1000 + 32'(len * 16 + rw);
    d = 32'h8000 + 32'(ww * 4);
    clear_logs();
    @(posedge clk); #1;
    src = s; dst = d; size_m1 = CNT_W'(len - 1); rwid = 3'(rw); wwid = 3'(ww);
    rinc = ri; winc = wi; bm1 = 8'(b); req_en = rq; preq = rq && !hold;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy && remaining == CNT_W'(len - 1), "R1", "remaining after start",
        remaining, len - 1);
    if (len >= 8) begin
      // R1: a second start while busy and changed settings must not matter
      @(posedge clk); #1;
      src = 32'h0; dst = 32'h4; size_m1 = 24'd2; rwid = 3'd0; wwid = 3'd1;
      rinc = 1'b0; winc = 1'b0; bm1 = 8'd0; req_en = 1'b1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    if (hold) begin
      repeat (20) @(negedge clk);
      chk(rd_cnt == 0 && wr_cnt == 0 && busy, "R6", "accesses without request",
          rd_cnt + wr_cnt, 0);
      @(posedge clk); #1;
      preq = 1'b1;
    end
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    preq = 1'b0;
    chk(done_cnt == 1, "R2", "done pulses", done_cnt, 1);
    chk(remaining == '1, "R2", "final remaining", remaining, 24'hFFFFFF);
    chk(!rd_req && !wr_req, "R9", "requests while idle", rd_req + wr_req, 0);

    // Model: burst split, then per-side chunking
    pos = 0; ri_n = 0; wi_n = 0; bad_len = 0; bad_addr = 0; bad_dat = 0;
    while (pos < len) begin
      int blen, off, n;
      logic [31:0] a;
      blen = (b + 1 < len - pos) ? b + 1 : len - pos;
      off = 0;
      while (off < blen) begin
        n = ((1 << rw) < blen - off) ? (1 << rw) : blen - off;
        a = ri ? s + 32'(pos + off) : s;
        if (ri_n < 256) begin
          if (rd_l[ri_n] != n) bad_len++;
          if (rd_a[ri_n] != a) bad_addr++;
        end
        for (int k = 0; k < n; k++) exp_s[pos + off + k] = pat(a + 32'(k));
        ri_n++; off += n;
      end
      off = 0;
      while (off < blen) begin
        n = ((1 << ww) < blen - off) ? (1 << ww) : blen - off;
        a = wi ? d + 32'(pos + off) : d;
        if (wi_n < 256) begin
          if (wr_l[wi_n] != n) bad_len++;
          if (wr_a[wi_n] != a) bad_addr++;
        end
        wi_n++; off += n;
      end
      pos += blen;
    end
    for (int q = 0; q < len; q++) if (stream[q] != exp_s[q]) bad_dat++;
    chk(rd_cnt == ri_n && wr_cnt == wi_n, "R4", "access counts", rd_cnt * 1000 + wr_cnt,
        ri_n * 1000 + wi_n);
    chk(bad_len == 0, "R4 R6", "access lengths per burst", bad_len, 0);
    chk(bad_addr == 0, "R5", "address sequence", bad_addr, 0);
    chk(bad_dat == 0 && wb == len, "R3", "byte stream", bad_dat * 100000 + wb, len);
  endtask

  initial begin
    #700000;
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] rem_b;
    int rc, wc;
    rst_n = 1'b0; start = 1'b0; cancel = 1'b0; preq = 1'b0; req_en = 1'b0;
    src = '0; dst = '0; size_m1 = '0; rwid = '0; wwid = '0; rinc = 1'b0; winc = 1'b0;
    bm1 = '0;
    clear_logs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8
    chk(!busy && !done && remaining == '1 && !rd_req && !wr_req, "R8", "reset state",
        {busy, done, rd_req, wr_req}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    for (int rw = 0; rw < 4; rw++)
      for (int ww = 0; ww < 4; ww++)
        for (int m = 0; m < 3; m++)
          run(13, rw, ww, m != 1, m != 0, 4, 1'b0, 1'b0);

    run(1, 3, 0, 1'b1, 1'b1, 4, 1'b0, 1'b0);
    run(1, 0, 3, 1'b0, 1'b1, 0, 1'b0, 1'b0);
    run(40, 3, 3, 1'b1, 1'b1, 255, 1'b0, 1'b0);
    run(24, 2, 1, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    run(21, 1, 3, 1'b1, 1'b0, 6, 1'b1, 1'b1);
    run(9, 0, 2, 1'b0, 1'b1, 2, 1'b1, 1'b0);

    // R7: cancel mid-transfer
    clear_logs();
    @(posedge clk); #1;
    src = 32'h2000; dst = 32'h9000; size_m1 = 24'd199; rwid = 3'd0; wwid = 3'd0;
    rinc = 1'b1; winc = 1'b1; bm1 = 8'd7; req_en = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (15) @(posedge clk);
    #1 cancel = 1'b1;
    @(negedge clk);
    rem_b = remaining; rc = rd_cnt; wc = wr_cnt;
    @(posedge clk); #1;
    cancel = 1'b0;
    @(negedge clk);
    chk(!busy, "R7", "busy after cancel", busy, 0);
    chk(remaining == rem_b && rem_b != '1, "R7", "remaining frozen", remaining, rem_b);
    repeat (10) @(negedge clk);
    chk(rd_cnt == rc && wr_cnt == wc, "R7", "accesses after cancel",
        rd_cnt + wr_cnt, rc + wc);
    chk(done_cnt == 0, "R7", "done after cancel", done_cnt, 0);
    run(17, 2, 3, 1'b1, 1'b1, 5, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule